// File: doc/BRIEF.md
# Operand Address Generation Unit

This block sits beside the execute stage of an 8-bit microcontroller datapath and turns operand references into memory addresses. A 3-bit register field from the opcode becomes an internal data memory address. The working-register bank is picked by two bits of the status word, so the same field can reach any of four groups of eight registers.

For table lookups, the block adds the accumulator, zero-extended to 16 bits, to a 16-bit base. The base is either the data pointer or the program counter. The sum goes out as a program-memory read address, and a read strobe goes with it. A separate strobe increments the 16-bit data pointer in one step and returns the new value for write-back. Each of the three paths registers its result once, so every result appears on the clock edge after its request.

Top module: `opaddr_unit`

## Requirements
- R1: After synchronous reset, `iram_addr`, `pm_addr` and `dptr_next` are 0, and `iram_vld`, `pm_rd` and `dptr_wr` are low.
- R2: One cycle after `reg_req` is high, `iram_vld` is high and `iram_addr` equals `status[4:3]` * 8 + `reg_fld`. In a cycle that follows no request, `iram_vld` is low and `iram_addr` keeps its last value.
- R3: `iram_addr` never exceeds 0x1F. Bits 7 to 5 are always zero.
- R4: One cycle after `tbl_req` with `tbl_from_pc` = 0, `pm_addr` equals `dptr_in` plus the zero-extended `acc`, modulo 65536.
- R5: One cycle after `tbl_req` with `tbl_from_pc` = 1, `pm_addr` equals `pc_next` plus the zero-extended `acc`, modulo 65536. `pc_next` is the address of the instruction after the lookup.
- R6: `pm_rd` is high in exactly the cycle after each cycle with `tbl_req` high, and low otherwise. The block has no program-memory write output. `pm_addr` holds its value when there is no request.
- R7: One cycle after `dptr_inc`, `dptr_wr` is high and `dptr_next` equals `dptr_in` + 1 modulo 65536. Otherwise `dptr_wr` is low and `dptr_next` holds its value.
- R8: Both 16-bit sums wrap. An increment of 0xFFFF gives 0x0000, and a base of 0xFFF0 plus an index of 0xFF gives 0x00EF.
- R9: Status bits other than 4 and 3 have no effect on `iram_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Request a register-operand address |
| reg_fld | input | 3 | Register number from the opcode |
| status | input | 8 | Status word; bits 4:3 select the bank |
| tbl_req | input | 1 | Request an indexed program-memory read |
| tbl_from_pc | input | 1 | Index base: 0 data pointer, 1 program counter |
| acc | input | 8 | Accumulator (table entry number) |
| dptr_in | input | 16 | Current data pointer |
| pc_next | input | 16 | Address of the following instruction |
| dptr_inc | input | 1 | Increment the data pointer |
| iram_addr | output | 8 | Internal data memory address |
| iram_vld | output | 1 | `iram_addr` updated this cycle |
| pm_addr | output | 16 | Program-memory read address |
| pm_rd | output | 1 | Program-memory read strobe |
| dptr_next | output | 16 | Incremented data pointer |
| dptr_wr | output | 1 | Write-back strobe for `dptr_next` |

## Verification
Every result of this block is due exactly one rising edge after the cycle in which its request is presented. This holds for the bank-mapped register address, the indexed read address with its strobe, and the incremented pointer. The driver applies each stimulus on a falling edge and queues the full expected output state for the next edge. The monitor pops that item one time unit after the rising edge, so each comparison falls in the single cycle where the result must appear. Idle cycles are queued as well, which checks that the strobes drop and the held values do not move.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

    localparam int WORD_W   = 8;   // accumulator width
    localparam int PTR_W    = 16;  // pointer / program address width
    localparam int FLD_W    = 3;   // register field width in the opcode
    localparam int BANK_W   = 2;   // bank-select width
    localparam int BANK_LSB = 3;   // position of bank select in the status word
    localparam int STAT_W   = 8;   // status word width
    localparam int IRAM_AW  = 8;   // internal data memory address width

    typedef enum logic {
        BASE_DPTR = 1'b0,
        BASE_PC   = 1'b1
    } base_sel_e;

    typedef struct packed {
        logic               vld;
        logic [IRAM_AW-1:0] addr;
    } iram_ref_t;

    typedef struct packed {
        logic             rd;
        logic [PTR_W-1:0] addr;
    } pm_ref_t;

    typedef struct packed {
        logic             wr;
        logic [PTR_W-1:0] val;
    } ptr_upd_t;

    // bank number * 2**FLD_W + register field, zero-extended
    function automatic logic [IRAM_AW-1:0] bank_addr(
        input logic [BANK_W-1:0] bank,
        input logic [FLD_W-1:0]  fld
    );
        return IRAM_AW'({bank, fld});
    endfunction

    // base plus zero-extended index, wrapping at the pointer width
    function automatic logic [PTR_W-1:0] index_sum(
        input logic [PTR_W-1:0]  base,
        input logic [WORD_W-1:0] idx
    );
        return base + PTR_W'(idx);
    endfunction

endpackage

// File: rtl/bank_reg_map.sv
module bank_reg_map
    import opaddr_pkg::*;
#(
    parameter int FW = FLD_W,
    parameter int BW = BANK_W,
    parameter int AW = IRAM_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [FW-1:0] fld,
    input  logic [BW-1:0] bank,
    output logic [AW-1:0] addr,
    output logic          vld
);
    localparam int SPAN_W = FW + BW;

    logic [AW-1:0] mapped;

    generate
        if (AW > SPAN_W) begin : g_pad
            assign mapped = {{(AW-SPAN_W){1'b0}}, bank, fld};
        end else begin : g_trim
            assign mapped = AW'({bank, fld});
        end
    endgenerate

    iram_ref_t ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= '0;
        end else begin
            ref_q.vld <= req;
            if (req) begin
                ref_q.addr <= IRAM_AW'(mapped);
            end
        end
    end

    assign addr = AW'(ref_q.addr);
    assign vld  = ref_q.vld;
endmodule

// File: rtl/table_addr_gen.sv
module table_addr_gen
    import opaddr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  base_sel_e         sel,
    input  logic [PTR_W-1:0]  dptr,
    input  logic [PTR_W-1:0]  pc,
    input  logic [WORD_W-1:0] idx,
    output logic [PTR_W-1:0]  addr,
    output logic              rd
);
    logic [PTR_W-1:0] base;
    pm_ref_t          ref_q;

    always_comb begin
        unique case (sel)
            BASE_PC: base = pc;
            default: base = dptr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= '0;
        end else begin
            ref_q.rd <= req;
            if (req) begin
                ref_q.addr <= index_sum(base, idx);
            end
        end
    end

    assign addr = ref_q.addr;
    assign rd   = ref_q.rd;
endmodule

// File: rtl/dptr_incr.sv
module dptr_incr
    import opaddr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic [PTR_W-1:0] cur,
    output logic [PTR_W-1:0] nxt,
    output logic             wr
);
    ptr_upd_t upd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_q <= '0;
        end else begin
            upd_q.wr <= inc;
            if (inc) begin
                upd_q.val <= cur + PTR_W'(1);
            end
        end
    end

    assign nxt = upd_q.val;
    assign wr  = upd_q.wr;
endmodule

// File: rtl/opaddr_unit.sv
module opaddr_unit
    import opaddr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_req,
    input  logic [2:0]  reg_fld,
    input  logic [7:0]  status,
    input  logic        tbl_req,
    input  logic        tbl_from_pc,
    input  logic [7:0]  acc,
    input  logic [15:0] dptr_in,
    input  logic [15:0] pc_next,
    input  logic        dptr_inc,
    output logic [7:0]  iram_addr,
    output logic        iram_vld,
    output logic [15:0] pm_addr,
    output logic        pm_rd,
    output logic [15:0] dptr_next,
    output logic        dptr_wr
);
    logic [BANK_W-1:0] bank_sel;
    base_sel_e         base_sel;

    assign bank_sel = status[BANK_LSB +: BANK_W];
    assign base_sel = tbl_from_pc ? BASE_PC : BASE_DPTR;

    bank_reg_map #(
        .FW (FLD_W),
        .BW (BANK_W),
        .AW (IRAM_AW)
    ) u_bank (
        .clk  (clk),
        .rst  (rst),
        .req  (reg_req),
        .fld  (reg_fld),
        .bank (bank_sel),
        .addr (iram_addr),
        .vld  (iram_vld)
    );

    table_addr_gen u_tbl (
        .clk  (clk),
        .rst  (rst),
        .req  (tbl_req),
        .sel  (base_sel),
        .dptr (dptr_in),
        .pc   (pc_next),
        .idx  (acc),
        .addr (pm_addr),
        .rd   (pm_rd)
    );

    dptr_incr u_dptr (
        .clk (clk),
        .rst (rst),
        .inc (dptr_inc),
        .cur (dptr_in),
        .nxt (dptr_next),
        .wr  (dptr_wr)
    );
endmodule

// File: rtl/opaddr_chk.sv
module opaddr_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_req,
    input logic [2:0]  reg_fld,
    input logic [7:0]  status,
    input logic        tbl_req,
    input logic        tbl_from_pc,
    input logic [7:0]  acc,
    input logic [15:0] dptr_in,
    input logic [15:0] pc_next,
    input logic        dptr_inc,
    input logic [7:0]  iram_addr,
    input logic        iram_vld,
    input logic [15:0] pm_addr,
    input logic        pm_rd,
    input logic [15:0] dptr_next,
    input logic        dptr_wr
);
    // R2
    ram_map_chk: assert property (@(posedge clk) disable iff (rst)
        reg_req |=> iram_vld && iram_addr == {3'b000, $past(status[4:3]), $past(reg_fld)});

    // R2
    ram_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_req |=> !iram_vld && $stable(iram_addr));

    // R3
    ram_range_chk: assert property (@(posedge clk) disable iff (rst)
        iram_addr[7:5] == 3'b000);

    // R4
    tbl_dptr_chk: assert property (@(posedge clk) disable iff (rst)
        (tbl_req && !tbl_from_pc) |=> pm_addr == $past(dptr_in) + {8'h00, $past(acc)});

    // R5
    tbl_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (tbl_req && tbl_from_pc) |=> pm_addr == $past(pc_next) + {8'h00, $past(acc)});

    // R6
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tbl_req |=> pm_rd);

    // R6
    rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !tbl_req |=> !pm_rd && $stable(pm_addr));

    // R7
    dptr_inc_chk: assert property (@(posedge clk) disable iff (rst)
        dptr_inc |=> dptr_wr && dptr_next == $past(dptr_in) + 16'd1);

    // R7
    dptr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !dptr_inc |=> !dptr_wr && $stable(dptr_next));
endmodule

bind opaddr_unit opaddr_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_req     (reg_req),
    .reg_fld     (reg_fld),
    .status      (status),
    .tbl_req     (tbl_req),
    .tbl_from_pc (tbl_from_pc),
    .acc         (acc),
    .dptr_in     (dptr_in),
    .pc_next     (pc_next),
    .dptr_inc    (dptr_inc),
    .iram_addr   (iram_addr),
    .iram_vld    (iram_vld),
    .pm_addr     (pm_addr),
    .pm_rd       (pm_rd),
    .dptr_next   (dptr_next),
    .dptr_wr     (dptr_wr)
);

// File: tb/tb_opaddr_unit.sv
module tb_opaddr_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_req, tbl_req, tbl_from_pc, dptr_inc;
    logic [2:0]  reg_fld;
    logic [7:0]  status, acc;
    logic [15:0] dptr_in, pc_next;
    logic [7:0]  iram_addr;
    logic        iram_vld, pm_rd, dptr_wr;
    logic [15:0] pm_addr, dptr_next;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    opaddr_unit dut (
        .clk(clk), .rst(rst), .reg_req(reg_req), .reg_fld(reg_fld), .status(status),
        .tbl_req(tbl_req), .tbl_from_pc(tbl_from_pc), .acc(acc), .dptr_in(dptr_in),
        .pc_next(pc_next), .dptr_inc(dptr_inc), .iram_addr(iram_addr), .iram_vld(iram_vld),
        .pm_addr(pm_addr), .pm_rd(pm_rd), .dptr_next(dptr_next), .dptr_wr(dptr_wr)
    );

    typedef struct {
        string       tag;
        logic [7:0]  ram;
        logic        ram_v;
        logic [15:0] pm;
        logic        rd;
        logic [15:0] dp;
        logic        wr;
    } exp_t;

    exp_t        sb[$];
    logic [7:0]  m_ram;
    logic [15:0] m_pm, m_dp;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag,
                        input logic rr, input logic [2:0] fld, input logic [7:0] st,
                        input logic tr, input logic from_pc, input logic [7:0] a,
                        input logic [15:0] dp, input logic [15:0] pc, input logic inc);
        exp_t e;
        @(negedge clk);
        reg_req = rr; reg_fld = fld; status = st;
        tbl_req = tr; tbl_from_pc = from_pc; acc = a;
        dptr_in = dp; pc_next = pc; dptr_inc = inc;
        if (rr)  m_ram = {3'b000, st[4:3], fld};
        if (tr)  m_pm  = (from_pc ? pc : dp) + {8'h00, a};
        if (inc) m_dp  = dp + 16'd1;
        e.tag = tag; e.ram = m_ram; e.ram_v = rr; e.pm = m_pm; e.rd = tr;
        e.dp = m_dp; e.wr = inc;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 1'b0);
    endtask

    // monitor: every queued item is due at the next rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " iram_addr"}, {8'h00, iram_addr}, {8'h00, e.ram});
                check({e.tag, " iram_vld"},  {15'h0, iram_vld},  {15'h0, e.ram_v});
                check({e.tag, " pm_addr"},   pm_addr,            e.pm);
                check({e.tag, " pm_rd"},     {15'h0, pm_rd},     {15'h0, e.rd});
                check({e.tag, " dptr_next"}, dptr_next,          e.dp);
                check({e.tag, " dptr_wr"},   {15'h0, dptr_wr},   {15'h0, e.wr});
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; reg_req = 0; reg_fld = 0; status = 0; tbl_req = 0; tbl_from_pc = 0;
        acc = 0; dptr_in = 0; pc_next = 0; dptr_inc = 0;
        m_ram = 0; m_pm = 0; m_dp = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 iram_addr", {8'h00, iram_addr}, 16'h0000);
        check("R1 strobes", {13'h0, iram_vld, pm_rd, dptr_wr}, 16'h0000);
        check("R1 pm_addr", pm_addr, 16'h0000);
        check("R1 dptr_next", dptr_next, 16'h0000);
        idle("R1 idle");

        // R2: bank mapping, bank 0..3
        step("R2 b0r1", 1, 3'd1, 8'h00, 0, 0, 8'h00, 16'h0000, 16'h0000, 0);
        step("R2 b1r0", 1, 3'd0, 8'h08, 0, 0, 8'h00, 16'h0000, 16'h0000, 0);
        step("R2 b2r5", 1, 3'd5, 8'h10, 0, 0, 8'h00, 16'h0000, 16'h0000, 0);
        idle("R2 hold");
        // R3: highest register 0x1F
        step("R3 b3r7", 1, 3'd7, 8'h18, 0, 0, 8'h00, 16'h0000, 16'h0000, 0);
        // R9: other status bits set, bank 1 r2 -> 0x0A
        step("R9 noise", 1, 3'd2, 8'hEF & 8'hEF, 0, 0, 8'h00, 16'h0000, 16'h0000, 0);
        step("R9 noise2", 1, 3'd2, 8'hE7 | 8'h08, 0, 0, 8'h00, 16'h0000, 16'h0000, 0);

        // R4: data pointer base (example table 0x1E73 + 0x3E)
        step("R4 dptr", 0, 3'd0, 8'h00, 1, 0, 8'h3E, 16'h1E73, 16'hAAAA, 0);
        idle("R6 idle");
        // R5: program counter base
        step("R5 pc", 0, 3'd0, 8'h00, 1, 1, 8'h80, 16'h5555, 16'h0102, 0);
        // R6: back-to-back requests give one pulse per request
        step("R6 b2b1", 0, 3'd0, 8'h00, 1, 0, 8'h01, 16'h0010, 16'h0000, 0);
        step("R6 b2b2", 0, 3'd0, 8'h00, 1, 1, 8'h02, 16'h0010, 16'h0020, 0);
        idle("R6 end");
        // R8: index wrap
        step("R8 tblwrap", 0, 3'd0, 8'h00, 1, 0, 8'hFF, 16'hFFF0, 16'h0000, 0);

        // R7: pointer increment
        step("R7 inc", 0, 3'd0, 8'h00, 0, 0, 8'h00, 16'h00FF, 16'h0000, 1);
        idle("R7 hold");
        // R8: pointer wrap
        step("R8 incwrap", 0, 3'd0, 8'h00, 0, 0, 8'h00, 16'hFFFF, 16'h0000, 1);

        // all three paths at once
        step("R2 R5 R7 mix", 1, 3'd6, 8'h10, 1, 1, 8'h22, 16'h1234, 16'h4000, 1);
        idle("mix end");
        idle("tail");
        @(posedge clk);
        #2;
        finish_run();
    end
endmodule